// File: doc/BRIEF.md
# Compare Timer with Self-Rearming Period Unit

This block is a memory-mapped timer frame that follows the 64-bit value of a system counter, which arrives on an input port. Software programs a 64-bit compare value, either directly or as a signed offset from the present count. When the timer is enabled and the count has reached the compare value, a status flag is set. An interrupt line follows that flag unless it is masked.

A second unit produces periodic interrupts. When it is switched on, it arms a 64-bit target at the present count plus a reload interval. Each time the count reaches the target, the unit sets a pending flag and moves the target forward by the interval. Software acknowledges the pending flag through a bit in the unit's own control register.

While the periodic unit is on, it supplies the status flag in place of the compare match. Every match decision uses the counter value that is present on the input. If the counter slows down or stalls, the events are delayed to match.

Top module: `cmp_timer_frame`

## Requirements
- R1: Out of reset the control register (0x2C) and the periodic control register (0x4C) read 0 and `irq_o` is low.
- R2: Offsets 0x00 and 0x04 read bits 31:0 and 63:32 of `count_i`.
- R3: Offset 0x10 reads the parameter `FREQ_RST` after reset and returns the last value written to it.
- R4: With the periodic unit off, status (control bit 2) is 1 exactly when control bit 0 (enable) is 1 and `count_i` >= the 64-bit compare value (0x20 low, 0x24 high), compared as unsigned numbers.
- R5: Control bit 0 is enable, bit 1 is interrupt mask, and bit 2 is read-only status. `irq_o` = enable AND status AND NOT mask, so a firing unmasked timer reads 5 and a firing masked timer reads 7.
- R6: A read of offset 0x28 returns compare[31:0] minus count[31:0], modulo 2^32.
- R7: A write of offset 0x28 sets the compare value to count plus the written word sign-extended to 64 bits.
- R8: A write to 0x4C with bit 0 = 1 while the unit is off turns it on, loads the target (0x40 low, 0x44 high) with count plus the reload interval (0x48), and clears pending. The same write while the unit is already on leaves the target unchanged.
- R9: With the unit on, the status bit equals pending. At the clock edge where `count_i` >= target, pending is set and the target advances by the reload interval.
- R10: A write to 0x4C with bit 1 = 0 clears pending; bit 1 = 1 leaves it. Offset 0x4C reads bit 0 = on and bit 1 = pending.
- R11: The count view and the target are full 64-bit quantities: the high halves are correct after a carry out of the low half.
- R12: While `count_i` holds below the target, no event occurs however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | System counter value |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Timer interrupt |

## Verification
The hardest case to reach is the periodic unit at the moment the counter meets its target. The hit must set pending and move the target in the same edge, and it must not hit a second time. An acknowledge write or a repeated enable write can fall near that moment. The bench drives `count_i` directly instead of waiting for a real counter. It parks the count just below the target for many cycles, then steps it exactly onto the target. It also jumps the count across a 32-bit boundary before arming, so the carry into the target's high half can be observed.

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] FREQ_RST = 32'd125_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       count_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_FREQ   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_DELTA  = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_PER_LO = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_PER_HI = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_IVL    = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_PCTL   = ADDR_W'(8'h4C);

  logic        run_q, mask_q, per_on_q, per_pend_q;
  logic [31:0] freq_q, ivl_q;
  logic [63:0] cmp_q, tgt_q;

  logic wr_ctl, wr_freq, wr_cmp_lo, wr_cmp_hi, wr_delta, wr_ivl, wr_pctl;
  assign wr_ctl    = wr_en && addr == A_CTL;
  assign wr_freq   = wr_en && addr == A_FREQ;
  assign wr_cmp_lo = wr_en && addr == A_CMP_LO;
  assign wr_cmp_hi = wr_en && addr == A_CMP_HI;
  assign wr_delta  = wr_en && addr == A_DELTA;
  assign wr_ivl    = wr_en && addr == A_IVL;
  assign wr_pctl   = wr_en && addr == A_PCTL;

  logic cmp_met, per_hit, status;
  assign cmp_met = count_i >= cmp_q;
  assign per_hit = per_on_q && (count_i >= tgt_q);
  assign status  = run_q && (per_on_q ? per_pend_q : cmp_met);
  assign irq_o   = status && !mask_q;

  logic [63:0] ivl_ext, delta_ext;
  assign ivl_ext   = {32'b0, ivl_q};
  assign delta_ext = {{32{wdata[31]}}, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      mask_q     <= 1'b0;
      per_on_q   <= 1'b0;
      per_pend_q <= 1'b0;
      freq_q     <= FREQ_RST;
      ivl_q      <= '0;
      cmp_q      <= '0;
      tgt_q      <= '0;
    end else begin
      if (wr_freq)   freq_q        <= wdata;
      if (wr_ctl)    {mask_q, run_q} <= wdata[1:0];
      if (wr_cmp_lo) cmp_q[31:0]   <= wdata;
      if (wr_cmp_hi) cmp_q[63:32]  <= wdata;
      if (wr_delta)  cmp_q         <= count_i + delta_ext;
      if (wr_ivl)    ivl_q         <= wdata;
      if (wr_pctl) begin
        per_on_q <= wdata[0];
        if (wdata[0] && !per_on_q) tgt_q <= count_i + ivl_ext;
        if (!wdata[1] || (wdata[0] && !per_on_q)) per_pend_q <= 1'b0;
      end
      if (per_hit) begin
        per_pend_q <= 1'b1;
        tgt_q      <= tgt_q + ivl_ext;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = count_i[31:0];
      A_CNT_HI: rdata = count_i[63:32];
      A_FREQ:   rdata = freq_q;
      A_CMP_LO: rdata = cmp_q[31:0];
      A_CMP_HI: rdata = cmp_q[63:32];
      A_DELTA:  rdata = cmp_q[31:0] - count_i[31:0];
      A_CTL:    rdata = {29'b0, status, mask_q, run_q};
      A_PER_LO: rdata = tgt_q[31:0];
      A_PER_HI: rdata = tgt_q[63:32];
      A_IVL:    rdata = ivl_q;
      A_PCTL:   rdata = {30'b0, per_pend_q, per_on_q};
      default:  rdata = '0;
    endcase
  end

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (run_q && !mask_q));

  a_r4_no_early_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !per_on_q && count_i < cmp_q) |-> !irq_o);

  a_r8_arm_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pctl && wdata[0] && !per_on_q) |=>
      (per_on_q && !per_pend_q && tgt_q == $past(count_i) + $past(ivl_ext)));

  a_r9_hit_advance: assert property (@(posedge clk) disable iff (!rst_n)
    per_hit |=> (per_pend_q && tgt_q == $past(tgt_q) + $past(ivl_ext)));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pctl && !wdata[1] && !per_hit) |=> !per_pend_q);
endmodule

// File: tb/cmp_timer_frame_tb_top.sv
module cmp_timer_frame_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  always #4 clk = ~clk;

  cmp_timer_frame dut_i (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic  mon_go = 1'b0;
  int    n_chk = 0;
  int    n_fail = 0;

  always @(negedge clk) begin
    if (mon_go && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a; mon_go = 1'b1;
    sb_q.push_back('{1'b0, e, tag});
    @(negedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(posedge clk); #1;
    addr = 8'hFC; mon_go = 1'b1;
    sb_q.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic set_cnt(input logic [63:0] v, input int hold);
    @(posedge clk); #1;
    count_i = v;
    repeat (hold) @(posedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    count_i = 64'h0000_0042_0000_1130;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(8'h2C, 32'h0, "R1 ctl");
    rd(8'h4C, 32'h0, "R1 pctl");
    chk_irq(1'b0, "R1 irq");
    // R2, R11 count view with high half
    rd(8'h00, 32'h0000_1130, "R2 cnt lo");
    rd(8'h04, 32'h0000_0042, "R11 cnt hi");
    // R3 frequency
    rd(8'h10, 32'd125_000_000, "R3 freq reset");
    wr(8'h10, 32'd1234);
    rd(8'h10, 32'd1234, "R3 freq write");
    // R4, R5, R6 compare path
    set_cnt(64'd100, 2);
    wr(8'h2C, 32'h1);
    wr(8'h20, 32'd4000);
    wr(8'h24, 32'd0);
    rd(8'h28, 32'd3900, "R6 delta read");
    set_cnt(64'd3999, 2);
    rd(8'h2C, 32'h1, "R4 below compare");
    set_cnt(64'd4000, 2);
    rd(8'h2C, 32'h5, "R4 at compare");
    chk_irq(1'b1, "R5 irq on");
    wr(8'h2C, 32'h3);
    rd(8'h2C, 32'h7, "R5 masked status");
    chk_irq(1'b0, "R5 irq masked");
    wr(8'h2C, 32'h1);
    // R4 unsigned 64-bit compare
    wr(8'h24, 32'h8000_0000);
    rd(8'h2C, 32'h1, "R4 unsigned high compare");
    wr(8'h24, 32'h0);
    rd(8'h2C, 32'h5, "R4 restored");
    // R7 delta write
    set_cnt(64'd5000, 2);
    wr(8'h28, 32'hFFFF_FF9C);
    rd(8'h20, 32'd4900, "R7 negative delta lo");
    rd(8'h24, 32'd0, "R7 negative delta hi");
    rd(8'h2C, 32'h5, "R7 status after negative");
    wr(8'h28, 32'd50);
    rd(8'h20, 32'd5050, "R7 positive delta");
    rd(8'h28, 32'd50, "R6 delta readback");
    rd(8'h2C, 32'h1, "R7 status cleared");
    // R8, R9 periodic unit
    set_cnt(64'd4000, 2);
    wr(8'h48, 32'd200);
    wr(8'h4C, 32'h1);
    rd(8'h40, 32'd4200, "R8 target lo");
    rd(8'h44, 32'd0, "R8 target hi");
    rd(8'h2C, 32'h1, "R8 pending clear");
    rd(8'h4C, 32'h1, "R8 pctl on");
    set_cnt(64'd4100, 2);
    rd(8'h2C, 32'h1, "R9 before target");
    set_cnt(64'd4200, 3);
    rd(8'h2C, 32'h5, "R9 hit status");
    rd(8'h40, 32'd4400, "R9 advanced once");
    rd(8'h4C, 32'h3, "R10 pending readback");
    chk_irq(1'b1, "R9 irq");
    // R10 acknowledge
    wr(8'h4C, 32'h3);
    rd(8'h2C, 32'h5, "R10 bit1 keeps pending");
    wr(8'h4C, 32'h1);
    rd(8'h2C, 32'h1, "R10 ack clears");
    rd(8'h40, 32'd4400, "R8 re-enable keeps target");
    // R12 stall
    set_cnt(64'd4300, 40);
    rd(8'h2C, 32'h1, "R12 stalled count no event");
    set_cnt(64'd4400, 3);
    rd(8'h2C, 32'h5, "R12 event once count arrives");
    rd(8'h40, 32'd4600, "R9 second advance");
    // R11 64-bit target
    wr(8'h4C, 32'h0);
    set_cnt(64'h0000_0042_0000_1130, 2);
    rd(8'h00, 32'd4400, "R11 count lo");
    rd(8'h04, 32'h42, "R11 count hi");
    wr(8'h4C, 32'h1);
    rd(8'h40, 32'd4600, "R11 target lo");
    rd(8'h44, 32'h42, "R11 target hi");
    wr(8'h4C, 32'h0);
    set_cnt(64'h0000_0000_FFFF_FF00, 2);
    wr(8'h48, 32'h200);
    wr(8'h4C, 32'h1);
    rd(8'h40, 32'h0000_0100, "R11 carry lo");
    rd(8'h44, 32'h1, "R11 carry hi");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule